// File: doc/BRIEF.md
# Stack Block-Transfer Address Sequencer

This block turns one multi-register stack transfer into a stream of single-word memory accesses. A request carries a base stack pointer, a mask with one bit per architectural register, a load/store flag, a write-back flag and a two-bit stack convention. Once it is accepted, the block walks the set mask bits from the lowest register number to the highest. For each register it presents a word address, the register index and a write strobe to a memory port that uses valid/ready flow control.

Four conventions are served. In a full stack the pointer marks the last occupied word; in an empty stack it marks the next free word. The stack grows either downward or upward. A store is a push and a load is a pop. Whatever the direction, the lowest-numbered register always sits at the lowest address. Load data is handed to the register file in the same cycle it arrives, tagged with its destination index. When the transfer ends the block pulses done and presents the resulting stack pointer. It also raises a return flag when a load included the program counter.

Top module: `stack_burst_seq`

## Requirements
- R1: After reset req_ready is 1, and mem_valid, done and pc_loaded are 0.
- R2: Registers are transferred in ascending index order, one per accepted beat. Each address is word-aligned and is 4 above the address of the previous beat, so the lowest index gets the lowest address.
- R3: With mode 2'b00 (full, descending) and n mask bits set, a store begins at sp-4n and a load begins at sp. The end pointer is sp-4n for a store and sp+4n for a load.
- R4: With mode 2'b01 (full, ascending), a store begins at sp+4 and a load begins at sp-4n+4. The end pointer is sp+4n for a store and sp-4n for a load.
- R5: With mode 2'b10 (empty, descending), a store begins at sp-4n+4 and a load begins at sp+4. The end pointer is sp-4n for a store and sp+4n for a load.
- R6: With mode 2'b11 (empty, ascending), a store begins at sp and a load begins at sp-4n. The end pointer is sp+4n for a store and sp-4n for a load.
- R7: mem_we is 1 for a store and 0 for a load. On each accepted load beat, rf_we is 1, rf_idx equals mem_reg and rf_wdata equals mem_rdata. On store beats rf_we is 0.
- R8: While done is 1, new_sp holds the end pointer when write-back was requested, and holds the base pointer otherwise.
- R9: A request with an all-zero mask produces no memory beat. It raises done in the cycle after acceptance, with new_sp equal to the base pointer.
- R10: While mem_valid is 1 and mem_ready is 0, mem_valid, mem_addr, mem_reg and mem_we hold their values into the next cycle.
- R11: done is 1 for exactly one cycle, the cycle after the final beat is accepted. req_ready is 0 from acceptance until done, and is 1 again in the cycle after done.
- R12: While done is 1, pc_loaded is 1 only for a load whose mask has bit 15 (the program counter) set. A store with bit 15 set or bit 14 (the link register) set leaves pc_loaded at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_sp | input | 32 | Base stack pointer (word-aligned) |
| req_mask | input | 16 | Register select mask, bit i selects register i |
| req_load | input | 1 | 1 = load (pop), 0 = store (push) |
| req_wback | input | 1 | Update the stack pointer at the end |
| req_mode | input | 2 | Bit 1: 1 empty / 0 full; bit 0: 1 ascending / 0 descending |
| mem_valid | output | 1 | Memory beat present |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Word address of the beat |
| mem_reg | output | 4 | Register index of the beat |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 32 | Read data, valid with an accepted load beat |
| rf_we | output | 1 | Register file write enable for load data |
| rf_idx | output | 4 | Destination register of load data |
| rf_wdata | output | 32 | Load data for the register file |
| done | output | 1 | One-cycle end-of-transfer pulse |
| new_sp | output | 32 | Resulting stack pointer, valid with done |
| pc_loaded | output | 1 | Program counter was loaded (return), valid with done |

## Verification
The properties assume that req_sp is word-aligned, because the alignment check on every beat depends on it. They also assume the memory side follows valid/ready rules: mem_ready may toggle in any cycle, and read data is meaningful only in an accepted load cycle. The stimulus uses only aligned pointers, placed far enough from zero and from the top of the address space that no sequence wraps. It changes mem_ready a few nanoseconds after each rising edge, from a pseudo-random pattern when stalls are enabled and held at 1 otherwise. Requests are applied only while the sequencer is idle, and the request is withdrawn right after it is accepted.

// File: rtl/stack_burst_seq.sv
module stack_burst_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_sp,
  input  logic [NREG-1:0]         req_mask,
  input  logic                    req_load,
  input  logic                    req_wback,
  input  logic [1:0]              req_mode,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [AW-1:0]           mem_addr,
  output logic [$clog2(NREG)-1:0] mem_reg,
  output logic                    mem_we,
  input  logic [AW-1:0]           mem_rdata,
  output logic                    rf_we,
  output logic [$clog2(NREG)-1:0] rf_idx,
  output logic [AW-1:0]           rf_wdata,
  output logic                    done,
  output logic [AW-1:0]           new_sp,
  output logic                    pc_loaded
);
  localparam int IW = $clog2(NREG);
  localparam int PC_IDX = NREG - 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t          state;
  logic [NREG-1:0] rem;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   sp_q;
  logic            ld_q;
  logic            pc_q;

  function automatic logic [AW-1:0] count_bytes(input logic [NREG-1:0] m);
    logic [AW-1:0] c;
    c = '0;
    for (int i = 0; i < NREG; i++) c = c + {{(AW-1){1'b0}}, m[i]};
    return c << 2;
  endfunction

  function automatic logic [IW-1:0] low_idx(input logic [NREG-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (m[i]) r = IW'(i);
    return r;
  endfunction

  logic          take;
  logic          beat;
  logic          going_down;
  logic          add_word;
  logic [AW-1:0] span;
  logic [AW-1:0] first_addr;
  logic [AW-1:0] end_sp;
  logic [NREG-1:0] rem_nxt;

  assign take       = req_valid && req_ready;
  assign beat       = mem_valid && mem_ready;
  assign going_down = ~(req_load ^ req_mode[0]);
  assign add_word   = going_down ? (req_mode[1] != req_load) : (req_mode[1] == req_load);
  assign span       = count_bytes(req_mask);
  assign first_addr = (going_down ? req_sp - span : req_sp) + (add_word ? AW'(4) : AW'(0));
  assign end_sp     = going_down ? req_sp - span : req_sp + span;
  assign rem_nxt    = rem & (rem - NREG'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rem    <= '0;
      addr_q <= '0;
      sp_q   <= '0;
      ld_q   <= 1'b0;
      pc_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          rem    <= req_mask;
          addr_q <= first_addr;
          sp_q   <= req_wback ? end_sp : req_sp;
          ld_q   <= req_load;
          pc_q   <= req_load && req_mask[PC_IDX];
          state  <= (req_mask == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (beat) begin
          rem    <= rem_nxt;
          addr_q <= addr_q + AW'(4);
          if (rem_nxt == '0) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign mem_valid = (state == S_RUN);
  assign mem_addr  = addr_q;
  assign mem_reg   = low_idx(rem);
  assign mem_we    = mem_valid && !ld_q;
  assign rf_we     = beat && ld_q;
  assign rf_idx    = mem_reg;
  assign rf_wdata  = mem_rdata;
  assign done      = (state == S_FIN);
  assign new_sp    = sp_q;
  assign pc_loaded = done && pc_q;
endmodule

// File: rtl/stack_burst_seq_chk.sv
module stack_burst_seq_chk #(
  parameter int AW   = 32,
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [AW-1:0]           mem_addr,
  input logic [$clog2(NREG)-1:0] mem_reg,
  input logic                    mem_we,
  input logic                    rf_we,
  input logic                    done
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_reg) && $stable(mem_we)));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + 4 && mem_reg > $past(mem_reg))));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  rf_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_valid && !mem_we));
endmodule

bind stack_burst_seq stack_burst_seq_chk #(.AW(AW), .NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_reg(mem_reg), .mem_we(mem_we), .rf_we(rf_we), .done(done)
);

// File: tb/stack_burst_seq_tb.sv
module stack_burst_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_sp = '0;
  logic [15:0] req_mask = '0;
  logic        req_load = 1'b0;
  logic        req_wback = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [3:0]  mem_reg;
  logic        mem_we;
  logic [31:0] mem_rdata;
  logic        rf_we;
  logic [3:0]  rf_idx;
  logic [31:0] rf_wdata;
  logic        done;
  logic [31:0] new_sp;
  logic        pc_loaded;

  int checks = 0;
  int fails  = 0;
  logic [36:0] exp_q[$];
  string cur_tag = "R2";
  logic  stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  always #10 clk = ~clk;

  assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

  stack_burst_seq dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #3;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  bit          prev_stall = 0;
  logic [31:0] prev_addr;
  logic [3:0]  prev_reg;
  bit          await_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (await_done) begin
        check(done === 1'b1, "R11 done after final beat", {31'd0, done}, 32'd1);
        await_done = 0;
      end
      if (prev_stall)
        check(mem_valid && mem_addr == prev_addr && mem_reg == prev_reg, "R10 stall hold", mem_addr, prev_addr);
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_reg   = mem_reg;
      if (mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected beat", mem_addr, 32'd0);
        end else begin
          logic [36:0] e;
          e = exp_q.pop_front();
          check(mem_addr == e[31:0], cur_tag, mem_addr, e[31:0]);
          check(mem_reg == e[35:32] && mem_we == e[36], "R2 reg order/strobe", {27'd0, mem_we, mem_reg}, {27'd0, e[36:32]});
          if (!e[36])
            check(rf_we && rf_idx == mem_reg && rf_wdata == mem_rdata, "R7 load tag", rf_wdata, mem_rdata);
          else
            check(!rf_we, "R7 store no rf write", {31'd0, rf_we}, 32'd0);
          if (exp_q.size() == 0) await_done = 1;
        end
      end
    end
  end

  task automatic run(input logic [31:0] sp, input logic [15:0] mask, input bit ld,
                     input bit wb, input logic [1:0] mode, input string tag);
    int n;
    logic [31:0] low, fin, exp_sp, s4;
    int k;
    n = $countones(mask);
    s4 = 32'(4 * n);
    case ({mode, ld})
      3'b000: begin low = sp - s4;     fin = sp - s4; end
      3'b001: begin low = sp;          fin = sp + s4; end
      3'b010: begin low = sp + 4;      fin = sp + s4; end
      3'b011: begin low = sp - s4 + 4; fin = sp - s4; end
      3'b100: begin low = sp - s4 + 4; fin = sp - s4; end
      3'b101: begin low = sp + 4;      fin = sp + s4; end
      3'b110: begin low = sp;          fin = sp + s4; end
      default: begin low = sp - s4;    fin = sp - s4; end
    endcase
    exp_sp = wb ? fin : sp;
    cur_tag = tag;
    k = 0;
    for (int i = 0; i < 16; i++)
      if (mask[i]) begin
        exp_q.push_back({~ld, 4'(i), low + 32'(4 * k)});
        k++;
      end
    @(negedge clk);
    check(req_ready === 1'b1, "R11 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_sp = sp; req_mask = mask; req_load = ld; req_wback = wb; req_mode = mode;
    @(negedge clk);
    req_valid = 1'b0;
    if (mask == 16'h0) begin
      check(done === 1'b1 && mem_valid === 1'b0, "R9 empty mask done", {31'd0, done}, 32'd1);
    end else begin
      check(req_ready === 1'b0, "R11 busy", {31'd0, req_ready}, 32'd0);
      while (done !== 1'b1) @(negedge clk);
      check(exp_q.size() == 0, "R11 done not early", exp_q.size(), 32'd0);
    end
    check(new_sp == exp_sp, wb ? "R8 writeback sp" : "R8 no writeback sp", new_sp, exp_sp);
    check(pc_loaded == (ld && mask[15]), "R12 pc flag", {31'd0, pc_loaded}, {31'd0, ld && mask[15]});
    @(negedge clk);
    check(done === 1'b0 && req_ready === 1'b1, "R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && mem_valid === 1'b0 && done === 1'b0 && pc_loaded === 1'b0,
          "R1 reset state", {28'd0, req_ready, mem_valid, done, pc_loaded}, 32'h8);
    rst_n = 1'b1;
    run(32'h0000_2000, 16'h5FF0, 0, 1, 2'b00, "R3 FD push");
    run(32'h0000_1FD8, 16'h9FF0, 1, 1, 2'b00, "R3 FD pop");
    run(32'h0000_3000, 16'h00F1, 0, 1, 2'b01, "R4 FA push");
    run(32'h0000_3014, 16'h00F1, 1, 1, 2'b01, "R4 FA pop");
    run(32'h0000_4000, 16'h4003, 0, 1, 2'b10, "R5 ED push");
    run(32'h0000_3FF4, 16'h8003, 1, 1, 2'b10, "R5 ED pop");
    run(32'h0000_5000, 16'hA50A, 0, 1, 2'b11, "R6 EA push");
    run(32'h0000_5018, 16'hA50A, 1, 1, 2'b11, "R6 EA pop");
    stall_en = 1'b1;
    run(32'h0000_6000, 16'hFFFF, 0, 1, 2'b00, "R3 FD push stalled");
    run(32'h0000_6000, 16'hFFFF, 1, 0, 2'b11, "R6 EA pop stalled");
    run(32'h0000_7000, 16'h0F0F, 1, 1, 2'b01, "R4 FA pop stalled");
    run(32'h0000_7100, 16'h3C3C, 0, 0, 2'b10, "R5 ED push stalled");
    stall_en = 1'b0;
    run(32'h0000_8000, 16'h0000, 1, 1, 2'b00, "R9 empty");
    run(32'h0000_8000, 16'h8000, 0, 1, 2'b00, "R3 FD push pc bit");
    run(32'h0000_8000, 16'h0001, 1, 1, 2'b10, "R5 ED pop single");
    run(32'h0000_8000, 16'h8000, 1, 0, 2'b01, "R4 FA pop pc only");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule